// File: doc/BRIEF.md
# Self-Timed Ripple FIFO Register

This block is a first-in first-out store for 4-bit words, 64 entries deep by default. It is built as a line of word slots rather than a RAM with read and write pointers. A word that is loaded at the input end moves forward one slot per clock while the slot ahead of it is free. An empty slot at the output end moves back toward the input in the same way, one slot per clock. The clock stands in for the asynchronous ripple delay of a self-timed register chain.

Each end has a strobe and a ready flag. The input end has `shift_in` and `in_ready`. The output end has `shift_out` and `out_ready`. A transfer takes place on the clock edge at which a strobe and its ready flag first become true together. The flags behave as short pulses. Because of that, two devices can be chained with no extra logic to make a deeper store:

- the upstream `out_ready` drives the downstream `shift_in`;
- the downstream `in_ready` drives the upstream `shift_out`;
- the upstream `out_en` is tied high.

The data output is tri-state and is driven only while `out_en` is high. The active-low master reset `mr_n` clears every slot at once. Its release is synchronised to the clock.

Top module: `ripple_fifo`

## Requirements
- R1: A device accepts DEPTH words with no removal and then holds `in_ready` low. A chain of two devices takes 2*DEPTH words: after 2*DEPTH-1 words have settled, `in_ready` is still high; after 2*DEPTH words have settled, it is low.
- R2: Words leave in the order they entered, with none lost or repeated. This also holds when a load and a removal happen on the same clock edge.
- R3: A word loaded into an empty device moves forward one slot per clock edge. `out_ready` goes high DEPTH-1 edges after the loading edge. In a two-device chain, the downstream `out_ready` goes high 2*DEPTH-1 edges after the loading edge.
- R4: After a removal from a full device, the free slot moves back one slot per edge. `in_ready` goes high DEPTH-1 edges after the removal edge. In a full two-device chain, the upstream `in_ready` goes high 2*DEPTH-1 edges after the downstream removal edge.
- R5: `in_ready` is high exactly when the input slot is empty. `out_ready` is high exactly when the output slot holds a word. While reset is active and after it, `in_ready` is 1 and `out_ready` is 0.
- R6: A strobe takes effect once, on the edge at which the strobe and its ready flag first become high together. A strobe pulse that ends while its flag is low has no effect.
- R7: On the edge where a word is removed, the output slot is not refilled. As a result, `out_ready` is low for at least one cycle after each removal.
- R8: `dout` carries the output-slot word while `out_en` is 1 and is high impedance while `out_en` is 0.
- R9: Driving `mr_n` low clears all slots at once, without waiting for a clock edge. After release, no word that was stored earlier reappears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one edge stands for one slot-to-slot ripple step |
| mr_n | input | 1 | Master reset, active low; asserts asynchronously, releases synchronously |
| shift_in | input | 1 | Load strobe |
| din | input | W | Word to load |
| in_ready | output | 1 | High when the input slot is empty |
| shift_out | input | 1 | Removal strobe |
| out_ready | output | 1 | High when the output slot holds a word |
| out_en | input | 1 | Output drive enable, active high |
| dout | output | W | Output-slot word, high impedance while `out_en` is 0 |

## Verification
The assertions assume that every strobe is a synchronous level that changes only away from the clock edge. They also assume that `din` is stable on the edge where a load is accepted. The bench drives its strobes and data only on falling clock edges and holds each strobe for a single cycle. When two devices are chained, the only thing driving the strobes is the other device's registered flags, so the handshake between the devices stays inside the same rule. Reset is asserted only from a falling edge.

// File: rtl/rf_pkg.sv
package rf_pkg;
  parameter int unsigned RF_WORD_W_DEF = 4;
  parameter int unsigned RF_DEPTH_DEF  = 64;
  parameter int unsigned RF_SYNC_STAGES = 2;
endpackage

// File: rtl/rf_rst_sync.sv
module rf_rst_sync #(
  parameter int unsigned STAGES = rf_pkg::RF_SYNC_STAGES
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/rf_strobe.sv
module rf_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic ready,
  output logic fire
);
  logic both_now;
  logic armed_q;
  logic armed_d;

  always_comb begin
    both_now = strobe && ready;
    armed_d  = both_now;
    fire     = both_now && !armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end
endmodule

// File: rtl/rf_stage.sv
module rf_stage #(
  parameter int unsigned W = rf_pkg::RF_WORD_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] src_word,
  input  logic         leave,
  output logic         held,
  output logic [W-1:0] word
);
  logic         held_q;
  logic         held_d;
  logic [W-1:0] word_q;
  logic [W-1:0] word_d;
  logic         word_en;

  always_comb begin
    held_d  = held_q;
    if (load)       held_d = 1'b1;
    else if (leave) held_d = 1'b0;
    word_en = load;
    word_d  = src_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= 1'b0;
    else        held_q <= held_d;
  end

  always_ff @(posedge clk) begin
    if (word_en) word_q <= word_d;
  end

  assign held = held_q;
  assign word = word_q;

  // R2: a slot is never loaded while it still holds a word
  a_r2_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !held_q);
  // R2: a held word keeps its value until it moves on
  a_r2_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !leave && !load) |=> $stable(word_q));
endmodule

// File: rtl/ripple_fifo.sv
module ripple_fifo #(
  parameter int unsigned W     = rf_pkg::RF_WORD_W_DEF,
  parameter int unsigned DEPTH = rf_pkg::RF_DEPTH_DEF
) (
  input  logic         clk,
  input  logic         mr_n,
  input  logic         shift_in,
  input  logic [W-1:0] din,
  output logic         in_ready,
  input  logic         shift_out,
  output logic         out_ready,
  input  logic         out_en,
  output logic [W-1:0] dout
);
  localparam int unsigned LAST = DEPTH - 1;

  logic             rst_n;
  logic             push;
  logic             pop;
  logic [DEPTH-1:0] held;
  logic [DEPTH-1:0] load;
  logic [DEPTH-1:0] leave;
  logic [DEPTH-2:0] move;
  logic [W-1:0]     word [DEPTH];
  logic [W-1:0]     src  [DEPTH];

  rf_rst_sync u_rst (
    .clk    (clk),
    .arst_n (mr_n),
    .rst_n  (rst_n)
  );

  rf_strobe u_in_strobe (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (shift_in),
    .ready  (in_ready),
    .fire   (push)
  );

  rf_strobe u_out_strobe (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (shift_out),
    .ready  (out_ready),
    .fire   (pop)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i == 0) begin : g_head
      assign load[i] = push;
      assign src[i]  = din;
    end else begin : g_body
      assign load[i] = move[i-1];
      assign src[i]  = word[i-1];
    end

    if (i == LAST) begin : g_tail
      assign leave[i] = pop;
    end else begin : g_fwd
      // a word steps forward only into a slot that is empty now
      assign move[i]  = held[i] && !held[i+1];
      assign leave[i] = move[i];

      // R3: a word facing an empty slot has moved into it one edge later
      a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (held[i] && !held[i+1]) |=> held[i+1]);
    end

    rf_stage #(.W(W)) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load[i]),
      .src_word (src[i]),
      .leave    (leave[i]),
      .held     (held[i]),
      .word     (word[i])
    );
  end

  assign in_ready  = !held[0];
  assign out_ready = held[LAST];
  assign dout      = out_en ? word[LAST] : {W{1'bz}};

  // R2: occupancy changes exactly by loads minus removals
  a_r2_conserve: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (int'($countones(held)) ==
      int'($countones($past(held))) + int'($past(push)) - int'($past(pop))));
  // R6: one accepted load drops in_ready on the next cycle
  a_r6_single_push: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !in_ready);
  // R7: the output slot is never refilled on a removal edge
  a_r7_gap: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !out_ready);
  // R6: a removal only happens when a word is present
  a_r6_pop_valid: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> held[LAST]);
endmodule

// File: tb/sim_ripple_fifo.sv
module sim_ripple_fifo;
  localparam int W = 4;
  localparam int D = 64;
  localparam int CAP = 2 * D;

  logic clk = 1'b0;
  logic mr_n;
  logic a_si, a_irdy, a_ordy, b_irdy, b_ordy, b_so, b_oe;
  logic [W-1:0] a_din, a_dout, b_dout;

  int errors = 0;
  int checks = 0;
  bit drain = 0;
  logic [W-1:0] sb [$];

  always #5 clk = ~clk;

  ripple_fifo #(.W(W), .DEPTH(D)) u0 (
    .clk(clk), .mr_n(mr_n), .shift_in(a_si), .din(a_din), .in_ready(a_irdy),
    .shift_out(b_irdy), .out_ready(a_ordy), .out_en(1'b1), .dout(a_dout));

  ripple_fifo #(.W(W), .DEPTH(D)) u1 (
    .clk(clk), .mr_n(mr_n), .shift_in(a_ordy), .din(a_dout), .in_ready(b_irdy),
    .shift_out(b_so), .out_ready(b_ordy), .out_en(b_oe), .dout(b_dout));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic take_word(input logic [W-1:0] got);
    logic [W-1:0] exp;
    if (sb.size() == 0) begin
      chk("R2 unexpected word", int'(got), -1);
    end else begin
      exp = sb.pop_front();
      chk("R2 order", int'(got), int'(exp));
    end
  endtask

  task automatic push_word(input logic [W-1:0] v);
    int n = 0;
    @(negedge clk);
    while (!a_irdy && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (!a_irdy) chk("R1 push wait", 0, 1);
    a_din = v;
    a_si  = 1'b1;
    sb.push_back(v);
    @(negedge clk);
    a_si = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: removes and scores words while drain is set
  initial begin
    b_so = 1'b0;
    forever begin
      @(negedge clk);
      if (drain) begin
        if (b_so) b_so = 1'b0;
        else if (b_ordy) begin
          take_word(b_dout);
          b_so = 1'b1;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    int w;
    mr_n = 1'b0; a_si = 1'b0; a_din = '0; b_oe = 1'b1;
    settle(4);
    chk("R5 reset in_ready", int'(a_irdy), 1);
    chk("R5 reset out_ready", int'(b_ordy), 0);
    mr_n = 1'b1;
    settle(4);
    chk("R5 idle in_ready", int'(b_irdy), 1);
    chk("R5 idle out_ready", int'(a_ordy), 0);

    // R3: latency of one word through the empty chain
    a_din = 4'h5; a_si = 1'b1; sb.push_back(4'h5);
    @(posedge clk);
    n = 0;
    forever begin
      @(negedge clk);
      a_si = 1'b0;
      if (b_ordy || n > 400) break;
      @(posedge clk);
      n++;
    end
    chk("R3 fall-through edges", n, CAP - 1);
    @(negedge clk);
    take_word(b_dout);
    b_so = 1'b1;
    @(negedge clk);
    b_so = 1'b0;
    chk("R7 out_ready low after removal", int'(b_ordy), 0);

    // R1: fill the chain
    for (int i = 0; i < CAP - 1; i++) push_word(W'((i % 15) + 1));
    settle(300);
    chk("R1 room after 2*DEPTH-1", int'(a_irdy), 1);
    push_word(4'hC);
    settle(300);
    chk("R1 full after 2*DEPTH", int'(a_irdy), 0);
    chk("R1 output ready when full", int'(b_ordy), 1);

    // R6: pulse while not ready is ignored
    a_din = 4'hF; a_si = 1'b1;
    @(negedge clk);
    a_si = 1'b0;
    settle(5);

    // R8: output enable
    b_oe = 1'b0;
    #1;
    chk("R8 released bus", int'(b_dout !== sb[0]), 1);
    b_oe = 1'b1;
    #1;
    chk("R8 driven bus", int'(b_dout), int'(sb[0]));

    // R4: hole travels back through the full chain
    @(negedge clk);
    take_word(b_dout);
    b_so = 1'b1;
    @(posedge clk);
    n = 0;
    forever begin
      @(negedge clk);
      b_so = 1'b0;
      if (a_irdy || n > 400) break;
      @(posedge clk);
      n++;
    end
    chk("R4 bubble edges", n, CAP - 1);

    push_word(4'h9);
    drain = 1'b1;
    w = 0;
    while (sb.size() != 0 && w < 5000) begin
      @(negedge clk);
      w++;
    end
    chk("R2 all words out", sb.size(), 0);
    settle(300);
    drain = 1'b0;
    chk("R6 ignored push left no word", int'(b_ordy), 0);
    chk("R5 empty chain in_ready", int'(a_irdy), 1);

    // R9: asynchronous clear
    push_word(4'h3);
    push_word(4'h4);
    settle(200);
    chk("R9 word present", int'(b_ordy), 1);
    mr_n = 1'b0;
    #1;
    chk("R9 out_ready cleared", int'(b_ordy), 0);
    chk("R9 in_ready set", int'(a_irdy), 1);
    sb.delete();
    settle(3);
    mr_n = 1'b1;
    settle(300);
    chk("R9 nothing reappears", int'(b_ordy), 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule